// File: doc/BRIEF.md
# Address Translation Buffer with Hardware Table Walk

This block converts 32-bit virtual addresses into physical addresses for a processor pipeline. A small fully associative cache of recent translations, with tags that hold both the virtual page number and a process identifier, answers most lookups in one cycle without touching memory. On a miss, a built-in walker fetches one 32-bit entry from a single-level linear page table in memory. It then installs the translation or reports why the page cannot be used.

Each request carries an access kind (load, store or instruction fetch). Pages are 4 KB, so the low 12 address bits pass through untranslated. The response carries the physical address, a flag that says whether the cached translations answered it, a fault code, and the dirty state of the page after the access. Each cached entry keeps a used bit and a dirty bit. The used bits guide replacement. Fault handling, backing store and data caches lie outside the block.

Page-table entry layout: bit 31 means resident and bit 30 means on disk. Bits 29:12 hold the physical frame number, bit 1 grants write permission, and bit 0 is ignored on fill. The number of entries must be a power of two.

Top module: `xlat_unit`

## Requirements
- R1: For every response with fault code 0, `resp_paddr` equals the frame number in bits 29:12 followed by `req_vaddr[11:0]` unchanged.
- R2: A request is a hit only when a valid entry matches both the virtual page number (`req_vaddr[31:12]`) and `req_pid`. A hit produces `resp_valid` with `resp_hit`=1 on the cycle after acceptance and issues no memory request.
- R3: A miss raises `mem_req_valid` for exactly one cycle, on the cycle after acceptance, with address = page-table base + 4 × virtual page number. The base resets to 0 and is loaded from `ptbase_wdata` when `ptbase_we` is high.
- R4: When a walk returns an entry with bit 31 set, the translation is installed. If bit 31 is clear and bit 30 is set, the fault code is 1 (on disk). If both bits are clear, the fault code is 2 (unmapped). A faulting walk installs nothing, so a repeat of the same page misses again.
- R5: Access kind is encoded as 0=load, 1=store, 2=fetch (3 acts as a load). A store to a page whose write bit (bit 1) is clear gets fault code 3, with `resp_paddr`=0 and `resp_dirty`=0, on a hit and after a walk. Loads and fetches are allowed on every resident page.
- R6: A store that is permitted sets the entry's dirty bit. `resp_dirty` reports the entry's dirty bit after the access, and the bit persists for later hits. Responses carrying fault 1 or 2 report `resp_dirty`=0.
- R7: The victim of an install is chosen in this order: the lowest-index invalid entry; otherwise the first entry with its used bit clear, searching upward from a round-robin pointer; otherwise the pointed-to entry, in which case the pointer advances by one. The installed entry's used bit is set and every other entry's used bit is cleared. A hit sets the used bit of the entry it hits.
- R8: `flush` invalidates every entry on the next clock edge. While `flush` is high, `req_ready` is low.
- R9: From acceptance of a miss until the walk result is reported, `req_ready` stays low and no other request is accepted.
- R10: Fault codes are 0=none, 1=on disk, 2=unmapped, 3=protection. Walk responses always report `resp_hit`=0. Responses with fault 1 or 2 report `resp_paddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_vaddr | input | VA_W (32) | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_pid | input | PID_W (4) | Process identifier |
| flush | input | 1 | Invalidate all cached translations |
| ptbase_we | input | 1 | Load the page-table base register |
| ptbase_wdata | input | PA_W (30) | New page-table base |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | PA_W (30) | Physical address of the page-table entry |
| mem_rsp_valid | input | 1 | Page-table read data present |
| mem_rsp_data | input | 32 | Page-table entry |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_hit | output | 1 | Answered from cached translations |
| resp_fault | output | 2 | Fault code |
| resp_dirty | output | 1 | Dirty state of the page after the access |
| resp_paddr | output | PA_W (30) | Physical address |

## Verification
The hardest state to reach from the ports is a full buffer whose used bits disagree with the round-robin pointer, because that is when the used-bit rule, and not the pointer, picks the victim. The stimulus gets there by filling both entries and then letting a later install age the other entry's used bit. The sequence then interleaves hits and further misses, so victims are chosen by the used bit in some steps and by the pointer tie-break in others. A behavioural model follows every install and eviction, so a revisited page's hit or miss outcome exposes a wrong victim. Protection faults on walked entries, on-disk and unmapped walks, identifier mismatches, and a relocated page-table base are mixed into the same sequence.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // access kind carried with each request
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  // response fault code
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_DISK  = 2'd1,
    FLT_NOMAP = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  // page-table entry layout
  localparam int PTE_W        = 32;
  localparam int PTE_RES_BIT  = 31;
  localparam int PTE_DISK_BIT = 30;
  localparam int PTE_WR_BIT   = 1;
  localparam int PTE_PFN_LSB  = 12;
  localparam int PAGE_OFF_W   = 12;

endpackage

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  ptbase,
  input  logic             mem_rsp_valid,
  output logic             idle,
  output logic             done,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr
);

  typedef enum logic [1:0] {WK_IDLE, WK_SEND, WK_WAIT} wk_state_e;

  wk_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= WK_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      case (state_q)
        WK_IDLE: begin
          if (start) begin
            state_q       <= WK_SEND;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ptbase + PA_W'({vpn, 2'b00});
          end
        end
        WK_SEND: begin
          state_q       <= WK_WAIT;
          mem_req_valid <= 1'b0;
        end
        WK_WAIT: begin
          if (mem_rsp_valid) state_q <= WK_IDLE;
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign idle = (state_q == WK_IDLE);
  assign done = (state_q == WK_WAIT) && mem_rsp_valid;

endmodule

// File: rtl/xlat_tags.sv
module xlat_tags #(
  parameter int ENTRIES = 2,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 4,
  parameter int PFN_W   = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  // lookup
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] lk_idx,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  output logic             lk_dirty,
  // hit update
  input  logic             touch_en,
  input  logic [(ENTRIES>1 ? $clog2(ENTRIES) : 1)-1:0] touch_idx,
  input  logic             touch_store,
  // install
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_dirty
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic             vld;
    logic             used;
    logic             wr;
    logic             dirty;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;
  } ent_t;

  ent_t             ent_q [ENTRIES];
  logic [IDX_W-1:0] rr_q;
  logic [ENTRIES-1:0] match;

  logic [IDX_W-1:0] vic_idx;
  logic             vic_tie;
  logic [IDX_W-1:0] cand;
  logic             found_free;
  logic             found_old;

  // parallel tag comparators, one per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = ent_q[e].vld && (ent_q[e].vpn == lk_vpn) && (ent_q[e].pid == lk_pid);
  end

  always_comb begin
    lk_hit   = |match;
    lk_idx   = '0;
    lk_pfn   = '0;
    lk_wr    = 1'b0;
    lk_dirty = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) begin
        lk_idx   = IDX_W'(e);
        lk_pfn   = ent_q[e].pfn;
        lk_wr    = ent_q[e].wr;
        lk_dirty = ent_q[e].dirty;
      end
    end
  end

  // victim choice: free slot, then unused slot from pointer, then pointer
  always_comb begin
    vic_idx    = rr_q;
    vic_tie    = 1'b1;
    cand       = rr_q;
    found_old  = 1'b0;
    found_free = 1'b0;
    for (int k = 0; k < ENTRIES; k++) begin
      cand = rr_q + IDX_W'(k);
      if (!found_old && !ent_q[cand].used) begin
        vic_idx   = cand;
        vic_tie   = 1'b0;
        found_old = 1'b1;
      end
    end
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found_free && !ent_q[e].vld) begin
        vic_idx    = IDX_W'(e);
        vic_tie    = 1'b0;
        found_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
      for (int e = 0; e < ENTRIES; e++) ent_q[e] <= '0;
    end else begin
      if (fill_en && !flush && vic_tie) rr_q <= vic_idx + IDX_W'(1);
      for (int e = 0; e < ENTRIES; e++) begin
        if (flush) begin
          ent_q[e].vld <= 1'b0;
        end else if (fill_en) begin
          if (vic_idx == IDX_W'(e)) begin
            ent_q[e].vld   <= 1'b1;
            ent_q[e].used  <= 1'b1;
            ent_q[e].wr    <= fill_wr;
            ent_q[e].dirty <= fill_dirty;
            ent_q[e].vpn   <= fill_vpn;
            ent_q[e].pid   <= fill_pid;
            ent_q[e].pfn   <= fill_pfn;
          end else begin
            ent_q[e].used <= 1'b0;
          end
        end else if (touch_en && touch_idx == IDX_W'(e)) begin
          ent_q[e].used <= 1'b1;
          if (touch_store) ent_q[e].dirty <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int PID_W   = 4,
  parameter int ENTRIES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic [PID_W-1:0] req_pid,
  input  logic             flush,
  input  logic             ptbase_we,
  input  logic [PA_W-1:0]  ptbase_wdata,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [1:0]       resp_fault,
  output logic             resp_dirty,
  output logic [PA_W-1:0]  resp_paddr
);

  localparam int OFF_W = PAGE_OFF_W;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PA_W-1:0]  ptbase_q;
  logic             wk_idle, wk_done;
  logic             accept, hit_acc, miss_acc, is_store, hit_prot;
  logic             lk_hit, lk_wr, lk_dirty;
  logic [IDX_W-1:0] lk_idx;
  logic [PFN_W-1:0] lk_pfn;

  logic [VPN_W-1:0] pend_vpn;
  logic [PID_W-1:0] pend_pid;
  logic [OFF_W-1:0] pend_off;
  logic             pend_store;

  logic             pte_res, pte_disk, pte_wr, walk_prot, fill_en;
  logic [PFN_W-1:0] pte_pfn;

  assign req_ready = wk_idle && !flush;
  assign accept    = req_valid && req_ready;
  assign is_store  = (req_kind == ACC_STORE);
  assign hit_acc   = accept && lk_hit;
  assign miss_acc  = accept && !lk_hit;
  assign hit_prot  = is_store && !lk_wr;

  assign pte_res   = mem_rsp_data[PTE_RES_BIT];
  assign pte_disk  = mem_rsp_data[PTE_DISK_BIT];
  assign pte_wr    = mem_rsp_data[PTE_WR_BIT];
  assign pte_pfn   = mem_rsp_data[PTE_PFN_LSB +: PFN_W];
  assign walk_prot = pend_store && !pte_wr;
  assign fill_en   = wk_done && pte_res && !flush;

  always_ff @(posedge clk) begin
    if (rst) ptbase_q <= '0;
    else if (ptbase_we) ptbase_q <= ptbase_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vpn   <= '0;
      pend_pid   <= '0;
      pend_off   <= '0;
      pend_store <= 1'b0;
    end else if (miss_acc) begin
      pend_vpn   <= req_vaddr[VA_W-1:OFF_W];
      pend_pid   <= req_pid;
      pend_off   <= req_vaddr[OFF_W-1:0];
      pend_store <= is_store;
    end
  end

  xlat_tags #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PID_W   (PID_W),
    .PFN_W   (PFN_W)
  ) u_tags (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .lk_vpn      (req_vaddr[VA_W-1:OFF_W]),
    .lk_pid      (req_pid),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_pfn      (lk_pfn),
    .lk_wr       (lk_wr),
    .lk_dirty    (lk_dirty),
    .touch_en    (hit_acc),
    .touch_idx   (lk_idx),
    .touch_store (is_store && lk_wr),
    .fill_en     (fill_en),
    .fill_vpn    (pend_vpn),
    .fill_pid    (pend_pid),
    .fill_pfn    (pte_pfn),
    .fill_wr     (pte_wr),
    .fill_dirty  (pend_store && pte_wr)
  );

  xlat_walker #(
    .VPN_W (VPN_W),
    .PA_W  (PA_W)
  ) u_walker (
    .clk           (clk),
    .rst           (rst),
    .start         (miss_acc),
    .vpn           (req_vaddr[VA_W-1:OFF_W]),
    .ptbase        (ptbase_q),
    .mem_rsp_valid (mem_rsp_valid),
    .idle          (wk_idle),
    .done          (wk_done),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr)
  );

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_fault <= FLT_NONE;
      resp_dirty <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (hit_acc) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b1;
        resp_fault <= hit_prot ? FLT_PROT : FLT_NONE;
        resp_dirty <= lk_dirty || (is_store && lk_wr);
        resp_paddr <= hit_prot ? '0 : {lk_pfn, req_vaddr[OFF_W-1:0]};
      end else if (wk_done) begin
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        if (pte_res) begin
          resp_fault <= walk_prot ? FLT_PROT : FLT_NONE;
          resp_dirty <= pend_store && pte_wr;
          resp_paddr <= walk_prot ? '0 : {pte_pfn, pend_off};
        end else begin
          resp_fault <= pte_disk ? FLT_DISK : FLT_NOMAP;
          resp_dirty <= 1'b0;
          resp_paddr <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            flush,
  input logic            mem_req_valid,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic [1:0]      resp_fault,
  input logic            resp_dirty,
  input logic [PA_W-1:0] resp_paddr
);

  p_hit_offset_r1: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit && resp_fault == 2'd0) |-> (resp_paddr[11:0] == $past(req_vaddr[11:0])));

  p_hit_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> $past(req_valid && req_ready));

  p_walk_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_walk_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && (resp_fault == 2'd1 || resp_fault == 2'd2)) |-> (!resp_hit && !resp_dirty && resp_paddr == '0));

  p_prot_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault == 2'd3) |-> (!resp_dirty && resp_paddr == '0));

  p_flush_block_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> !req_ready);

  p_busy_block_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

endmodule

bind xlat_unit xlat_unit_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .flush         (flush),
  .mem_req_valid (mem_req_valid),
  .resp_valid    (resp_valid),
  .resp_hit      (resp_hit),
  .resp_fault    (resp_fault),
  .resp_dirty    (resp_dirty),
  .resp_paddr    (resp_paddr)
);

// File: tb/xlat_unit_bench.sv
`timescale 1ns/1ps
module xlat_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [3:0]  req_pid = '0;
  logic        flush = 1'b0;
  logic        ptbase_we = 1'b0;
  logic [29:0] ptbase_wdata = '0;
  logic        mem_req_valid;
  logic [29:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        resp_valid, resp_hit, resp_dirty;
  logic [1:0]  resp_fault;
  logic [29:0] resp_paddr;

  always #5 clk = ~clk;

  xlat_unit u_xlat_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_pid(req_pid),
    .flush(flush), .ptbase_we(ptbase_we), .ptbase_wdata(ptbase_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_dirty(resp_dirty), .resp_paddr(resp_paddr)
  );

  int checks = 0;
  int fails  = 0;
  bit resp_slot = 1'b0;

  // page table in memory, keyed by physical address; missing means unmapped
  logic [31:0] ptmem [int unsigned];

  // reference model state
  bit          m_vld [2];
  logic [19:0] m_vpn [2];
  logic [3:0]  m_pid [2];
  logic [17:0] m_pfn [2];
  bit          m_wr [2];
  bit          m_used [2];
  bit          m_dirty [2];
  int          m_rr = 0;
  logic [29:0] m_ptb = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_res(input logic [17:0] pfn, input bit wr);
    return {1'b1, 1'b0, pfn, 10'd0, wr, 1'b0};
  endfunction

  function automatic logic [31:0] pte_get(input logic [29:0] a);
    if (ptmem.exists(int'(a))) return ptmem[int'(a)];
    return 32'd0;
  endfunction

  task automatic tick(input bit slot);
    @(negedge clk);
    resp_slot = slot;
  endtask

  // every cycle: a response appears exactly where the model expects one
  always begin
    @(posedge clk);
    #7;
    if (!rst) chk(resp_valid === resp_slot, "R2", "resp_valid timing", 64'(resp_valid), 64'(resp_slot));
  end

  task automatic access(input logic [31:0] va, input logic [1:0] kind,
                        input logic [3:0] pid, input int lat, input string tag);
    int hi;
    int v;
    bit st;
    logic [19:0] vpn;
    logic [31:0] pte;
    logic [29:0] exp_pa;
    logic [1:0]  exp_f;
    bit exp_d;
    vpn = va[31:12];
    st  = (kind == 2'd1);
    tick(0);
    chk(req_ready === 1'b1, "R9", "ready before request", 64'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_pid = pid;
    hi = -1;
    for (int i = 0; i < 2; i++)
      if (m_vld[i] && m_vpn[i] == vpn && m_pid[i] == pid) hi = i;
    if (hi >= 0) begin
      m_used[hi] = 1'b1;
      if (st && m_wr[hi]) m_dirty[hi] = 1'b1;
      exp_f  = (st && !m_wr[hi]) ? 2'd3 : 2'd0;
      exp_pa = (exp_f != 0) ? 30'd0 : {m_pfn[hi], va[11:0]};
      exp_d  = m_dirty[hi];
      tick(1);
      req_valid = 1'b0;
      chk(resp_hit === 1'b1, tag, "hit flag", 64'(resp_hit), 1);
      chk(mem_req_valid === 1'b0, "R2", "no walk on hit", 64'(mem_req_valid), 0);
    end else begin
      tick(0);
      req_valid = 1'b0;
      chk(mem_req_valid === 1'b1, "R3", "walk request", 64'(mem_req_valid), 1);
      chk(mem_req_addr === m_ptb + {vpn, 2'b00}, "R3", "entry address",
          64'(mem_req_addr), 64'(m_ptb + {vpn, 2'b00}));
      chk(req_ready === 1'b0, "R9", "ready during walk", 64'(req_ready), 0);
      pte = pte_get(m_ptb + {vpn, 2'b00});
      tick(0);
      for (int w = 0; w < lat; w++) tick(0);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      if (pte[31]) begin
        v = -1;
        for (int i = 0; i < 2; i++) if (v < 0 && !m_vld[i]) v = i;
        for (int k = 0; k < 2; k++) if (v < 0 && !m_used[(m_rr + k) % 2]) v = (m_rr + k) % 2;
        if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % 2; end
        for (int i = 0; i < 2; i++) m_used[i] = 1'b0;
        m_vld[v] = 1'b1; m_used[v] = 1'b1; m_vpn[v] = vpn; m_pid[v] = pid;
        m_pfn[v] = pte[29:12]; m_wr[v] = pte[1]; m_dirty[v] = st && pte[1];
        exp_f  = (st && !pte[1]) ? 2'd3 : 2'd0;
        exp_pa = (exp_f != 0) ? 30'd0 : {pte[29:12], va[11:0]};
        exp_d  = m_dirty[v];
      end else begin
        exp_f  = pte[30] ? 2'd1 : 2'd2;
        exp_pa = '0;
        exp_d  = 1'b0;
      end
      tick(1);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      chk(resp_hit === 1'b0, "R10", "walk reports no hit", 64'(resp_hit), 0);
    end
    chk(resp_fault === exp_f, tag, "fault code", 64'(resp_fault), 64'(exp_f));
    chk(resp_paddr === exp_pa, tag, "physical address", 64'(resp_paddr), 64'(exp_pa));
    chk(resp_dirty === exp_d, tag, "dirty", 64'(resp_dirty), 64'(exp_d));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ptmem[32'h0000] = pte_res(18'h00010, 1'b0);   // vpn 0, read-only
    ptmem[32'h001C] = pte_res(18'h00027, 1'b1);   // vpn 7, writable
    ptmem[32'h0008] = 32'h4000_0000;              // vpn 2, on disk
    ptmem[32'h0010] = pte_res(18'h00031, 1'b1);   // vpn 4
    ptmem[32'h0014] = pte_res(18'h00005, 1'b0);   // vpn 5, read-only
    ptmem[32'h1048] = pte_res(18'h0003A, 1'b1);   // vpn 0x12 under base 0x1000
    ptmem[32'h1010] = pte_res(18'h00044, 1'b1);   // vpn 4 under base 0x1000

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(req_ready === 1'b1, "R9", "reset ready", 64'(req_ready), 1);
    chk(resp_valid === 1'b0, "R2", "reset resp_valid", 64'(resp_valid), 0);
    chk(mem_req_valid === 1'b0, "R3", "reset walk idle", 64'(mem_req_valid), 0);

    access(32'h0000_0ABC, 2'd0, 4'd1, 2, "R3");   // base 0 at reset
    access(32'h0000_0123, 2'd0, 4'd1, 0, "R1");
    access(32'h0000_0FF0, 2'd1, 4'd1, 0, "R5");   // store to read-only hit
    access(32'h0000_0004, 2'd2, 4'd1, 0, "R5");   // fetch allowed
    access(32'h0000_7FFC, 2'd1, 4'd1, 1, "R6");   // store miss dirties
    access(32'h0000_7010, 2'd0, 4'd1, 0, "R6");   // dirty persists
    access(32'h0000_2134, 2'd0, 4'd1, 3, "R4");   // on disk
    access(32'h0000_2138, 2'd0, 4'd1, 0, "R4");   // not installed: walks again
    access(32'h0000_3000, 2'd2, 4'd1, 1, "R10");  // unmapped
    access(32'h0000_4008, 2'd0, 4'd1, 0, "R7");
    access(32'h0000_5008, 2'd0, 4'd1, 2, "R7");
    access(32'h0000_4010, 2'd0, 4'd1, 0, "R7");
    access(32'h0000_7020, 2'd0, 4'd1, 0, "R7");
    access(32'h0000_0ABC, 2'd0, 4'd1, 1, "R7");
    access(32'h0000_4018, 2'd0, 4'd2, 0, "R2");   // other process
    access(32'h0000_4018, 2'd0, 4'd1, 0, "R2");

    tick(0);
    flush = 1'b1;
    #1;
    chk(req_ready === 1'b0, "R8", "ready during flush", 64'(req_ready), 0);
    tick(0);
    flush = 1'b0;
    for (int i = 0; i < 2; i++) m_vld[i] = 1'b0;
    access(32'h0000_4018, 2'd0, 4'd2, 0, "R8");   // was cached before flush

    tick(0);
    ptbase_we = 1'b1; ptbase_wdata = 30'h1000;
    tick(0);
    ptbase_we = 1'b0;
    m_ptb = 30'h1000;
    access(32'h0001_2345, 2'd1, 4'd1, 1, "R3");
    access(32'h0000_5004, 2'd1, 4'd3, 0, "R5");   // unmapped under new base
    access(32'h0000_4ABC, 2'd1, 4'd3, 2, "R6");

    for (int n = 0; n < 8; n++) begin
      access({12'd0, (n % 2 == 0) ? 8'h12 : 8'h04, 12'((n * 12'h1F3) & 12'hFFF)},
             2'(n % 3), (n % 2 == 0) ? 4'd1 : 4'd3, n % 3, "R1");
    end

    m_ptb = 30'h0;
    tick(0);
    ptbase_we = 1'b1; ptbase_wdata = 30'h0;
    tick(0);
    ptbase_we = 1'b0;
    access(32'h0000_5FFC, 2'd1, 4'd1, 1, "R5");   // store walk to read-only page
    access(32'h0000_5FF8, 2'd0, 4'd1, 0, "R5");   // installed anyway, now a hit

    tick(0);
    tick(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule